// File: doc/BRIEF.md
# Multicycle Accumulator Processor with Interrupt Cycle

This block is a small processor with one accumulator. It runs a program held in a single memory that stores both instructions and data. Each instruction is one 16-bit word. The upper four bits select the operation and the lower twelve bits give a direct memory address. Every memory transfer passes through an internal address register and an internal buffer register. A fetched word is copied into an instruction register before it is decoded. The block drives a synchronous memory port: the read data appears one cycle after the read strobe.

Each instruction moves through a fixed series of named states:
- `ST_FETCH_ADDR` loads the address register from the PC.
- `ST_FETCH_READ` issues the read and increments the PC.
- `ST_FETCH_LATCH` captures the word in the buffer register.
- `ST_DECODE` fills the instruction register and loads the operand address.
- `ST_EXECUTE` takes the decision for the current opcode.

Operand handling uses further states:
- `ST_OPER_READ`, `ST_OPER_LATCH` and `ST_OPER_APPLY` serve load and add.
- `ST_OPER_WRITE` serves store.

Jump, return, halt and no-op finish in `ST_EXECUTE`. Every instruction except halt ends in `ST_INT_CHECK`. From there, a pending and unmasked request leads to `ST_INT_ENTER`; otherwise control goes back to `ST_FETCH_ADDR`. `ST_INT_ENTER` saves the PC and the accumulator into shadow registers, loads the PC with the handler vector, masks further requests and pulses the acknowledge output. Halt leads to `ST_HALTED`, which the block leaves only through reset.

Top module: `acc_cpu`

## Requirements
- R1: After reset the first read strobe carries address 0x300. The opcode of each instruction is bits 15:12 and its operand address is bits 11:0.
- R2: Opcode 0x1 replaces the accumulator with the word at the operand address.
- R3: Opcode 0x5 adds the word at the operand address to the accumulator. The sum is kept modulo 2^16.
- R4: Opcode 0x2 writes the accumulator to the operand address in exactly one write cycle. A cycle never asserts read and write together.
- R5: The PC advances by one per fetch. Opcode 0x8 makes the next fetch come from its 12-bit address, and the word that follows the jump is not executed.
- R6: Opcode 0xF raises the halt output, which then stays high. While halted there are no reads, no writes and no acknowledges, even when a request arrives.
- R7: Every opcode other than 0x1, 0x2, 0x5, 0x8, 0xE and 0xF leaves the accumulator unchanged and writes nothing to memory.
- R8: The block samples a latched request after each instruction. It then pulses the acknowledge output for one cycle, and the next read strobe carries address 0x010.
- R9: Opcode 0xE restores the PC and the accumulator saved at interrupt entry and unmasks requests. The interrupted program then continues with its accumulator intact.
- R10: A request raised while the handler runs is held and does not cause entry until the handler has returned. It is then taken.
- R11: Load and add take 9 cycles, store takes 7, and jump, no-op and return take 6. Halt is reached 5 cycles after its fetch begins, so the program load, add, store, halt is halted 30 cycles after reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address, taken from the address register |
| mem_wdata | output | 16 | Write data, taken from the buffer register |
| mem_rdata | input | 16 | Read data, valid one cycle after a read strobe |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| irq_req | input | 1 | Interrupt request, latched until taken |
| irq_ack | output | 1 | One-cycle pulse on entry to the handler |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The add path is swept over a grid of 64 operand pairs. The grid includes zero, one, both sign boundaries and all-ones, so a correct carry out of bit 15 can be told apart from a wrong one. Each run of that program also checks the cycle count to halt and the number of write strobes. Together these separate a wrong state sequence from a wrong arithmetic result. Every unused opcode is placed between a load and a store, which shows whether it disturbs the accumulator or memory. A jump program shows that the skipped word is never executed. An interrupt program raises one request in the main program and a second inside the handler. The handler's own counter, the restored accumulator and the position of the second acknowledge relative to the return fetch tell masking, context restore and held requests apart.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR,
        ST_FETCH_READ,
        ST_FETCH_LATCH,
        ST_DECODE,
        ST_EXECUTE,
        ST_OPER_READ,
        ST_OPER_LATCH,
        ST_OPER_APPLY,
        ST_OPER_WRITE,
        ST_INT_CHECK,
        ST_INT_ENTER,
        ST_HALTED
    } cpu_state_e;

    localparam logic [3:0] OPC_LOAD  = 4'h1;
    localparam logic [3:0] OPC_STORE = 4'h2;
    localparam logic [3:0] OPC_ADD   = 4'h5;
    localparam logic [3:0] OPC_JUMP  = 4'h8;
    localparam logic [3:0] OPC_RETI  = 4'hE;
    localparam logic [3:0] OPC_HALT  = 4'hF;

    // Datapath strobes issued by the sequencer
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_mbr;
        logic pc_inc;
        logic pc_from_ir;
        logic mbr_from_mem;
        logic mbr_from_ac;
        logic ir_from_mbr;
        logic ac_from_mbr;
        logic ac_add_mbr;
        logic ctx_save;
        logic ctx_restore;
        logic mem_re;
        logic mem_we;
        logic irq_ack;
        logic halt;
    } ctl_s;

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int OPC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             irq_take_ok,
    output ctl_s             ctl
);

    cpu_state_e state_q;
    cpu_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH_ADDR;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH_ADDR:  state_d = ST_FETCH_READ;
            ST_FETCH_READ:  state_d = ST_FETCH_LATCH;
            ST_FETCH_LATCH: state_d = ST_DECODE;
            ST_DECODE:      state_d = ST_EXECUTE;
            ST_EXECUTE: begin
                case (opcode)
                    OPC_LOAD,
                    OPC_ADD:   state_d = ST_OPER_READ;
                    OPC_STORE: state_d = ST_OPER_WRITE;
                    OPC_HALT:  state_d = ST_HALTED;
                    default:   state_d = ST_INT_CHECK;
                endcase
            end
            ST_OPER_READ:   state_d = ST_OPER_LATCH;
            ST_OPER_LATCH:  state_d = ST_OPER_APPLY;
            ST_OPER_APPLY:  state_d = ST_INT_CHECK;
            ST_OPER_WRITE:  state_d = ST_INT_CHECK;
            ST_INT_CHECK:   state_d = irq_take_ok ? ST_INT_ENTER : ST_FETCH_ADDR;
            ST_INT_ENTER:   state_d = ST_FETCH_ADDR;
            ST_HALTED:      state_d = ST_HALTED;
            default:        state_d = ST_FETCH_ADDR;
        endcase
    end

    // Outputs
    always_comb begin
        ctl = '0;
        unique case (state_q)
            ST_FETCH_ADDR:  ctl.mar_from_pc = 1'b1;
            ST_FETCH_READ: begin
                ctl.mem_re = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            ST_FETCH_LATCH: ctl.mbr_from_mem = 1'b1;
            ST_DECODE: begin
                ctl.ir_from_mbr  = 1'b1;
                ctl.mar_from_mbr = 1'b1;
            end
            ST_EXECUTE: begin
                case (opcode)
                    OPC_STORE: ctl.mbr_from_ac = 1'b1;
                    OPC_JUMP:  ctl.pc_from_ir  = 1'b1;
                    OPC_RETI:  ctl.ctx_restore = 1'b1;
                    default:   ;
                endcase
            end
            ST_OPER_READ:   ctl.mem_re = 1'b1;
            ST_OPER_LATCH:  ctl.mbr_from_mem = 1'b1;
            ST_OPER_APPLY: begin
                if (opcode == OPC_LOAD) begin
                    ctl.ac_from_mbr = 1'b1;
                end else begin
                    ctl.ac_add_mbr = 1'b1;
                end
            end
            ST_OPER_WRITE:  ctl.mem_we = 1'b1;
            ST_INT_CHECK:   ;
            ST_INT_ENTER: begin
                ctl.ctx_save = 1'b1;
                ctl.irq_ack  = 1'b1;
            end
            ST_HALTED:      ctl.halt = 1'b1;
            default:        ;
        endcase
    end

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
    import acc_cpu_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int          OPC_W    = 4,
    parameter int          ADDR_W   = DATA_W - OPC_W,
    parameter int unsigned RESET_PC = 'h300,
    parameter int unsigned VECTOR   = 'h010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_s              ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [OPC_W-1:0]  opcode
);

    localparam logic [ADDR_W-1:0] PC_INIT  = ADDR_W'(RESET_PC);
    localparam logic [ADDR_W-1:0] PC_VEC   = ADDR_W'(VECTOR);
    localparam logic [ADDR_W-1:0] PC_STEP  = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mbr_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] ac_q;
    logic [ADDR_W-1:0] shadow_pc_q;
    logic [DATA_W-1:0] shadow_ac_q;

    // Program counter: vector, restore, jump, then increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= PC_INIT;
        end else if (ctl.ctx_save) begin
            pc_q <= PC_VEC;
        end else if (ctl.ctx_restore) begin
            pc_q <= shadow_pc_q;
        end else if (ctl.pc_from_ir) begin
            pc_q <= ir_q[ADDR_W-1:0];
        end else if (ctl.pc_inc) begin
            pc_q <= pc_q + PC_STEP;
        end
    end

    // Address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else if (ctl.mar_from_pc) begin
            mar_q <= pc_q;
        end else if (ctl.mar_from_mbr) begin
            mar_q <= mbr_q[ADDR_W-1:0];
        end
    end

    // Buffer register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbr_q <= '0;
        end else if (ctl.mbr_from_mem) begin
            mbr_q <= mem_rdata;
        end else if (ctl.mbr_from_ac) begin
            mbr_q <= ac_q;
        end
    end

    // Instruction register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (ctl.ir_from_mbr) begin
            ir_q <= mbr_q;
        end
    end

    // Accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q <= '0;
        end else if (ctl.ctx_restore) begin
            ac_q <= shadow_ac_q;
        end else if (ctl.ac_from_mbr) begin
            ac_q <= mbr_q;
        end else if (ctl.ac_add_mbr) begin
            ac_q <= ac_q + mbr_q;
        end
    end

    // Shadow context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_pc_q <= '0;
            shadow_ac_q <= '0;
        end else if (ctl.ctx_save) begin
            shadow_pc_q <= pc_q;
            shadow_ac_q <= ac_q;
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign opcode    = ir_q[DATA_W-1 -: OPC_W];

endmodule

// File: rtl/acc_cpu_irq.sv
module acc_cpu_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic take,
    input  logic release_mask,
    output logic take_ok
);

    logic pending_q;
    logic enabled_q;

    // A request raised in the entry cycle stays held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= (pending_q & ~take) | irq_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled_q <= 1'b1;
        end else if (take) begin
            enabled_q <= 1'b0;
        end else if (release_mask) begin
            enabled_q <= 1'b1;
        end
    end

    assign take_ok = pending_q & enabled_q;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter  int          DATA_W   = 16,
    parameter  int          OPC_W    = 4,
    parameter  int unsigned RESET_PC = 'h300,
    parameter  int unsigned VECTOR   = 'h010,
    localparam int          ADDR_W   = DATA_W - OPC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic              irq_req,
    output logic              irq_ack,
    output logic              halted
);

    ctl_s             ctl;
    logic [OPC_W-1:0] opcode;
    logic             take_ok;

    acc_cpu_ctrl #(
        .OPC_W (OPC_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .opcode      (opcode),
        .irq_take_ok (take_ok),
        .ctl         (ctl)
    );

    acc_cpu_datapath #(
        .DATA_W   (DATA_W),
        .OPC_W    (OPC_W),
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC),
        .VECTOR   (VECTOR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .opcode    (opcode)
    );

    acc_cpu_irq u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_req      (irq_req),
        .take         (ctl.irq_ack),
        .release_mask (ctl.ctx_restore),
        .take_ok      (take_ok)
    );

    assign mem_we  = ctl.mem_we;
    assign mem_re  = ctl.mem_re;
    assign irq_ack = ctl.irq_ack;
    assign halted  = ctl.halt;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
    parameter int          ADDR_W = 12,
    parameter int unsigned VECTOR = 'h010
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic              irq_ack,
    input logic              halted
);

    // R6
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R6
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_re && !mem_we && !irq_ack));

    // R4
    single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R4
    write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R8
    vector_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> ##1 (mem_re && mem_addr == ADDR_W'(VECTOR)));

endmodule

bind acc_cpu acc_cpu_chk #(
    .ADDR_W (ADDR_W),
    .VECTOR (VECTOR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .irq_ack  (irq_ack),
    .halted   (halted)
);

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_we;
    logic        mem_re;
    logic        irq_req = 1'b0;
    logic        irq_ack;
    logic        halted;

    logic [15:0] mem [0:4095];

    int checks = 0;
    int fails  = 0;

    logic mon_clear = 1'b0;
    int   ack_cnt;
    int   we_cnt;
    int   reti_reads;
    int   quiet_bad;
    logic late_ok;

    always #2 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .irq_req   (irq_req),
        .irq_ack   (irq_ack),
        .halted    (halted)
    );

    // Synchronous memory: read data one cycle after the strobe
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    // Port monitor
    always @(negedge clk) begin
        if (mon_clear) begin
            ack_cnt = 0; we_cnt = 0; reti_reads = 0; quiet_bad = 0; late_ok = 1'b0;
        end else if (rst_n) begin
            if (irq_ack) begin
                if (ack_cnt == 1) late_ok = (reti_reads >= 1);
                ack_cnt++;
            end
            if (mem_we) we_cnt++;
            if (mem_re && mem_addr == 12'h013) reti_reads++;
            if (halted && (mem_re || mem_we)) quiet_bad++;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        #760000;
        fails++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    endtask

    task automatic start_run();
        rst_n = 1'b0;
        irq_req = 1'b0;
        mon_clear = 1'b1;
        repeat (3) @(negedge clk);
        mon_clear = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic run_to_halt(output int cyc);
        cyc = 0;
        while (!halted && cyc < 3000) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic logic [15:0] pick(int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            5: return 16'h1234;
            6: return 16'hABCD;
            default: return 16'h00FF;
        endcase
    endfunction

    initial begin
        int cyc;
        logic [15:0] a;
        logic [15:0] b;

        // Reset state and first fetch address (R1)
        clear_mem();
        mem[12'h300] = 16'hF000;
        start_run();
        check("R1 reset re", {31'd0, mem_re}, 32'd0);
        check("R1 reset we", {31'd0, mem_we}, 32'd0);
        check("R6 reset halt", {31'd0, halted}, 32'd0);
        check("R8 reset ack", {31'd0, irq_ack}, 32'd0);
        @(posedge clk); @(negedge clk);
        check("R1 first fetch strobe", {31'd0, mem_re}, 32'd1);
        check("R1 first fetch addr", {20'd0, mem_addr}, 32'h300);

        // Add sweep: load, add, store, halt (R2 R3 R4 R11)
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                a = pick(i);
                b = pick(j);
                clear_mem();
                mem[12'h300] = 16'h1900;
                mem[12'h301] = 16'h5901;
                mem[12'h302] = 16'h2902;
                mem[12'h303] = 16'hF000;
                mem[12'h900] = a;
                mem[12'h901] = b;
                mem[12'h902] = 16'hDEAD;
                start_run();
                run_to_halt(cyc);
                check("R3 sum", {16'd0, mem[12'h902]}, {16'd0, 16'(a + b)});
                check("R11 cycles to halt", cyc, 30);
                check("R4 write count", we_cnt, 1);
            end
        end

        // Halted stays quiet under a request (R6)
        irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        repeat (8) @(negedge clk);
        check("R6 halt held", {31'd0, halted}, 32'd1);
        check("R6 no ack while halted", ack_cnt, 0);
        check("R6 no access while halted", quiet_bad, 0);

        // Load alone (R2)
        clear_mem();
        mem[12'h300] = 16'h1A00;
        mem[12'h301] = 16'h2A01;
        mem[12'h302] = 16'hF000;
        mem[12'hA00] = 16'h5A5A;
        start_run();
        run_to_halt(cyc);
        check("R2 loaded value stored", {16'd0, mem[12'hA01]}, 32'h5A5A);

        // Unused opcodes as no-ops (R7)
        for (int op = 0; op < 16; op++) begin
            if (op == 1 || op == 2 || op == 5 || op == 8 || op == 14 || op == 15) continue;
            clear_mem();
            mem[12'h300] = 16'h1900;
            mem[12'h301] = {4'(op), 12'h903};
            mem[12'h302] = 16'h2902;
            mem[12'h303] = 16'hF000;
            mem[12'h900] = 16'hC3A5;
            mem[12'h903] = 16'h1111;
            start_run();
            run_to_halt(cyc);
            check("R7 accumulator kept", {16'd0, mem[12'h902]}, 32'hC3A5);
            check("R7 no extra write", we_cnt, 1);
            check("R7 operand untouched", {16'd0, mem[12'h903]}, 32'h1111);
        end

        // Jump skips the next word (R5)
        clear_mem();
        mem[12'h300] = 16'h1900;
        mem[12'h301] = 16'h8340;
        mem[12'h302] = 16'h2905;
        mem[12'h340] = 16'h2906;
        mem[12'h341] = 16'hF000;
        mem[12'h900] = 16'h0777;
        mem[12'h905] = 16'hBEEF;
        start_run();
        run_to_halt(cyc);
        check("R5 skipped store", {16'd0, mem[12'h905]}, 32'hBEEF);
        check("R5 jump target store", {16'd0, mem[12'h906]}, 32'h0777);
        check("R5 halted after jump", {31'd0, halted}, 32'd1);

        // Interrupts: one in main, one inside handler (R8 R9 R10)
        clear_mem();
        mem[12'h300] = 16'h1900;
        mem[12'h301] = 16'h5901;
        mem[12'h302] = 16'h5901;
        mem[12'h303] = 16'h2902;
        mem[12'h304] = 16'hF000;
        mem[12'h010] = 16'h10F0;
        mem[12'h011] = 16'h50F1;
        mem[12'h012] = 16'h20F0;
        mem[12'h013] = 16'hE000;
        mem[12'h0F1] = 16'h0001;
        mem[12'h900] = 16'h0100;
        mem[12'h901] = 16'h0023;
        start_run();
        fork
            run_to_halt(cyc);
            begin
                repeat (3) @(negedge clk);
                irq_req = 1'b1;
                @(negedge clk);
                irq_req = 1'b0;
                for (int w = 0; w < 200 && ack_cnt < 1; w++) @(negedge clk);
                repeat (5) @(negedge clk);
                irq_req = 1'b1;
                @(negedge clk);
                irq_req = 1'b0;
            end
        join
        check("R8 ack count", ack_cnt, 2);
        check("R8 handler entries", {16'd0, mem[12'h0F0]}, 32'd2);
        check("R9 accumulator restored", {16'd0, mem[12'h902]}, 32'h0146);
        check("R10 second entry after return", {31'd0, late_ok}, 32'd1);
        check("R9 main resumed to halt", {31'd0, halted}, 32'd1);

        summary();
        $finish;
    end

endmodule